// File: doc/BRIEF.md
# Bit-serial CRC-8 accumulator with stored-value readout

This block keeps a running 8-bit check value over a bit-serial stream. Every bit that crosses the serial line, whether header or payload and in either direction, is presented on `bit_in` together with a one-cycle `bit_en` strobe. While `run` is high the register folds each bit into its state with a reflected shift-right LFSR. While `run` is low the register is cleared and takes no bits. Bytes are fed least significant bit first, so a header sent with its own check byte appended leaves the register at zero.

When a transaction ends (`run` falls), the register value at that moment is copied into a capture register. A later transaction may raise `rd_sel` together with `run`. In that case the working register is loaded from the capture register and then shifts it out on `rd_bit`, least significant bit first, one bit per strobe. Every falling edge of `run` overwrites the captured value, including the edge that ends a readout.

Top module: `crc8_serial_acc`

## Requirements
- R1: After reset, `crc_val` is 0, `crc_ok` is 0 and `rd_bit` is 0, and the captured value is 0.
- R2: On any clock edge where `run` is low, the register is cleared to 0 and `bit_en` has no effect.
- R3: With `run` high and `rd_sel` low, each `bit_en` strobe computes fb = `bit_in` XOR `crc_val[0]`. The new value is `crc_val` shifted right by one, XORed with 8'hE6 when fb is 1. This places fb in bit 7.
- R4: A multi-byte stream fed least significant bit first gives the check value of the bytes in order, starting from 0.
- R5: `crc_ok` is high exactly when `run` is high, `rd_sel` is low and `crc_val` is 0. Any bytes followed by their check byte (LSB first) leave `crc_ok` high.
- R6: On the edge where `run` is first seen low after being high, the capture register takes the current `crc_val`. At no other edge does it change, so each later transaction end overwrites it.
- R7: On the first edge with `run` and `rd_sel` both high, the register loads the captured value. After that, each `bit_en` strobe shifts it right with zero fill, and `bit_in` is ignored. `rd_bit` then equals captured bit k after k strobes.
- R8: `rd_bit` is 0 in the cycle after any edge where `run` or `rd_sel` was low.
- R9: With `run` high and `bit_en` low, and outside the loading edge of R7, `crc_val` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Transaction active; low clears and disables the register |
| rd_sel | input | 1 | Readout select: shift captured value out instead of accumulating |
| bit_en | input | 1 | One-cycle strobe marking a serial bit |
| bit_in | input | 1 | Serial data bit seen on the line |
| crc_val | output | 8 | Current register contents |
| crc_ok | output | 1 | Register is zero while accumulating |
| rd_bit | output | 1 | Serial readout bit (register bit 0 during readout) |

## Verification
On every cycle, the assertions check the one-bit update rule against the previous register value and input bit. They also check clearing while `run` is low, holding without a strobe, and loading the captured value on readout entry. The capture register must change only when `run` falls, and the readout output must stay silent outside readout mode. The bench scenarios are what show whole-byte behaviour: a sweep over all 256 byte values with and without their check byte appended, multi-byte headers, and a full eight-bit readout of many captured values. They also show that a readout destroys the captured value and that a second transaction overwrites the first.

// File: rtl/crc8_acc_pkg.sv
package crc8_acc_pkg;

  // Operation applied to the working register on the next enabled edge.
  typedef enum logic [2:0] {
    CRC_OP_HOLD  = 3'd0,
    CRC_OP_CLEAR = 3'd1,
    CRC_OP_ACCUM = 3'd2,
    CRC_OP_LOAD  = 3'd3,
    CRC_OP_SHIFT = 3'd4
  } crc_op_e;

endpackage

// File: rtl/crc8_mode_ctl.sv
module crc8_mode_ctl
  import crc8_acc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    rd_sel,
  input  logic    bit_en,
  output crc_op_e op,
  output logic    capture,
  output logic    run_q,
  output logic    rd_mode_q
);

  logic rd_mode;
  logic rd_enter;

  assign rd_mode  = run & rd_sel;
  assign rd_enter = rd_mode & ~rd_mode_q;
  assign capture  = run_q & ~run;

  // Operation decode: clearing wins, then readout entry, then per-bit work.
  always_comb begin
    op = CRC_OP_HOLD;
    if (!run) begin
      op = CRC_OP_CLEAR;
    end else if (rd_enter) begin
      op = CRC_OP_LOAD;
    end else if (bit_en) begin
      op = rd_mode ? CRC_OP_SHIFT : CRC_OP_ACCUM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      rd_mode_q <= 1'b0;
    end else begin
      run_q     <= run;
      rd_mode_q <= rd_mode;
    end
  end

endmodule

// File: rtl/crc8_lfsr_core.sv
module crc8_lfsr_core
  import crc8_acc_pkg::*;
#(
  parameter int unsigned        CRC_W   = 8,
  parameter logic [CRC_W-1:0]   FB_MASK = 8'hE6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  crc_op_e          op,
  input  logic             bit_in,
  input  logic [CRC_W-1:0] load_val,
  output logic [CRC_W-1:0] crc_q
);

  logic [CRC_W-1:0] crc_d;
  logic             crc_en;
  logic             fb;

  assign crc_en = (op != CRC_OP_HOLD);

  always_comb begin
    fb    = bit_in ^ crc_q[0];
    crc_d = crc_q;
    case (op)
      CRC_OP_CLEAR: crc_d = '0;
      CRC_OP_ACCUM: crc_d = (crc_q >> 1) ^ (fb ? FB_MASK : '0);
      CRC_OP_LOAD:  crc_d = load_val;
      CRC_OP_SHIFT: crc_d = crc_q >> 1;
      default:      crc_d = crc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

endmodule

// File: rtl/crc8_save_reg.sv
module crc8_save_reg #(
  parameter int unsigned CRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [CRC_W-1:0] d,
  output logic [CRC_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (capture) begin
      q <= d;
    end
  end

endmodule

// File: rtl/crc8_serial_acc.sv
module crc8_serial_acc
  import crc8_acc_pkg::*;
#(
  parameter int unsigned      CRC_W   = 8,
  parameter logic [CRC_W-1:0] FB_MASK = 8'hE6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rd_sel,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_val,
  output logic             crc_ok,
  output logic             rd_bit
);

  crc_op_e          op;
  logic             capture;
  logic             run_q;
  logic             rd_mode_q;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] saved_q;

  crc8_mode_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .rd_sel    (rd_sel),
    .bit_en    (bit_en),
    .op        (op),
    .capture   (capture),
    .run_q     (run_q),
    .rd_mode_q (rd_mode_q)
  );

  crc8_lfsr_core #(
    .CRC_W   (CRC_W),
    .FB_MASK (FB_MASK)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .bit_in   (bit_in),
    .load_val (saved_q),
    .crc_q    (crc_q)
  );

  crc8_save_reg #(
    .CRC_W (CRC_W)
  ) u_save (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .d       (crc_q),
    .q       (saved_q)
  );

  assign crc_val = crc_q;
  assign crc_ok  = run & ~rd_sel & ~(|crc_q);
  assign rd_bit  = rd_mode_q & crc_q[0];

endmodule

// File: rtl/crc8_serial_acc_chk.sv
module crc8_serial_acc_chk #(
  parameter int unsigned      CRC_W   = 8,
  parameter logic [CRC_W-1:0] FB_MASK = 8'hE6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             rd_sel,
  input logic             bit_en,
  input logic             bit_in,
  input logic [CRC_W-1:0] crc_val,
  input logic             rd_bit,
  input logic             run_q,
  input logic             rd_mode_q,
  input logic [CRC_W-1:0] saved_q
);

  // R2
  clear_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (crc_val == '0));

  // R3
  lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rd_sel && bit_en) |=>
      (crc_val == (($past(crc_val) >> 1) ^
                   (($past(crc_val[0]) ^ $past(bit_in)) ? FB_MASK : '0))));

  // R9
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_en && !(rd_sel && !rd_mode_q)) |=> $stable(crc_val));

  // R6
  capture_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !run) |=> (saved_q == $past(crc_val)));

  // R6
  capture_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && !run) |=> $stable(saved_q));

  // R7
  readout_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rd_sel && !rd_mode_q) |=> (crc_val == $past(saved_q)));

  // R7
  readout_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rd_sel && rd_mode_q && bit_en) |=> (crc_val == ($past(crc_val) >> 1)));

  // R8
  readout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !rd_sel) |=> !rd_bit);

endmodule

bind crc8_serial_acc crc8_serial_acc_chk #(
  .CRC_W   (CRC_W),
  .FB_MASK (FB_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .rd_sel    (rd_sel),
  .bit_en    (bit_en),
  .bit_in    (bit_in),
  .crc_val   (crc_val),
  .rd_bit    (rd_bit),
  .run_q     (run_q),
  .rd_mode_q (rd_mode_q),
  .saved_q   (saved_q)
);

// File: tb/crc8_serial_acc_tb_top.sv
`timescale 1ns/1ps
module crc8_serial_acc_tb_top;

  logic       clk;
  logic       rst_n;
  logic       run;
  logic       rd_sel;
  logic       bit_en;
  logic       bit_in;
  logic [7:0] crc_val;
  logic       crc_ok;
  logic       rd_bit;

  int errors;
  int checks;
  bit done;

  crc8_serial_acc dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .rd_sel  (rd_sel),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .crc_val (crc_val),
    .crc_ok  (crc_ok),
    .rd_bit  (rd_bit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference step in the byte-oriented form: xor 0xCC, then rotate fb in.
  function automatic logic [7:0] ref_bit(logic [7:0] c, logic b);
    logic       f;
    logic [7:0] t;
    f = b ^ c[0];
    t = f ? (c ^ 8'hCC) : c;
    return {f, t[7:1]};
  endfunction

  function automatic logic [7:0] ref_byte(logic [7:0] c, logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = ref_bit(r, d[i]);
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(logic en, logic b);
    bit_en = en;
    bit_in = b;
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] d);
    for (int i = 0; i < 8; i++) tick(1'b1, d[i]);
  endtask

  task automatic end_txn();
    run = 1'b0;
    rd_sel = 1'b0;
    tick(1'b0, 1'b0);
  endtask

  task automatic readout(logic [7:0] exp, string req);
    logic [7:0] got;
    run = 1'b1;
    rd_sel = 1'b1;
    tick(1'b0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      got[k] = rd_bit;
      tick(1'b1, 1'b1);
    end
    check(got == exp, req, got, exp);
  endtask

  initial begin
    errors = 0;
    checks = 0;
    done = 0;
    rst_n = 1'b0;
    run = 1'b0;
    rd_sel = 1'b0;
    bit_en = 1'b0;
    bit_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(crc_val == 8'h00, "R1 crc_val", crc_val, 0);
    check(crc_ok == 1'b0, "R1 crc_ok", crc_ok, 0);
    check(rd_bit == 1'b0, "R1 rd_bit", rd_bit, 0);
    readout(8'h00, "R1 captured value");
    end_txn();

    // R3 R4 R5 R2: every byte value, alone then followed by its check byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      e = ref_byte(8'h00, v[7:0]);
      run = 1'b1;
      send_byte(v[7:0]);
      check(crc_val == e, "R3 single byte", crc_val, e);
      check(crc_ok == (e == 8'h00), "R5 flag on byte", crc_ok, (e == 8'h00));
      send_byte(e);
      check(crc_val == 8'h00, "R5 residue zero", crc_val, 0);
      check(crc_ok == 1'b1, "R5 ok after check byte", crc_ok, 1);
      end_txn();
      check(crc_val == 8'h00, "R2 cleared when run low", crc_val, 0);
    end

    // R2 strobes with run low are ignored
    run = 1'b0;
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b1);
    check(crc_val == 8'h00, "R2 strobes ignored", crc_val, 0);
    check(crc_ok == 1'b0, "R5 flag low when idle", crc_ok, 0);

    // R4 R5 six-byte headers plus check byte, then payload bytes
    for (int h = 0; h < 8; h++) begin
      logic [7:0] e;
      logic [7:0] d;
      e = 8'h00;
      run = 1'b1;
      for (int j = 0; j < 6; j++) begin
        d = 8'(h * 37 + j * 91 + 5);
        e = ref_byte(e, d);
        send_byte(d);
      end
      check(crc_val == e, "R4 header value", crc_val, e);
      send_byte(e);
      check(crc_ok == 1'b1, "R5 header accepted", crc_ok, 1);
      e = 8'h00;
      for (int j = 0; j < 4; j++) begin
        d = 8'(h * 13 + j * 200 + 1);
        e = ref_byte(e, d);
        send_byte(d);
      end
      check(crc_val == e, "R4 payload stream", crc_val, e);
      // R9 no strobe: bit_in toggling does not change the register
      tick(1'b0, 1'b1);
      tick(1'b0, 1'b0);
      check(crc_val == e, "R9 hold without strobe", crc_val, e);
      // R8 quiet while accumulating
      check(rd_bit == 1'b0, "R8 rd_bit while accumulating", rd_bit, 0);
      end_txn();
      // R6 R7 read captured value back, bit_in held at 1 (ignored)
      readout(e, "R7 readout of captured value");
      check(crc_ok == 1'b0, "R5 flag low in readout", crc_ok, 0);
      end_txn();
      // R6 the readout end overwrote the capture with the drained register
      readout(8'h00, "R6 capture destroyed by readout");
      end_txn();
    end

    // R6 a later transaction overwrites an earlier one
    begin
      logic [7:0] ea;
      logic [7:0] eb;
      ea = ref_byte(8'h00, 8'h5A);
      eb = ref_byte(ref_byte(8'h00, 8'hC3), 8'h11);
      run = 1'b1;
      send_byte(8'h5A);
      end_txn();
      run = 1'b1;
      send_byte(8'hC3);
      send_byte(8'h11);
      end_txn();
      readout(eb, "R6 latest transaction kept");
      check(ea != eb, "R6 distinct values", ea, eb);
      end_txn();
    end

    // R8 rd_sel high with run low keeps rd_bit low
    rd_sel = 1'b1;
    run = 1'b0;
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
    check(rd_bit == 1'b0, "R8 rd_bit with run low", rd_bit, 0);
    rd_sel = 1'b0;

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule